// File: doc/BRIEF.md
# Parallel Lookup-Table Reservoir Array

This block is a fully unrolled delay-loop reservoir. It holds `N` state cells of `DW`-bit signed fixed point. Each cell has its own constant input weight and bias, and its own three constant lookup maps:

- an input-mask map, which replaces the weight multiply and the bias add;
- a leak map, which scales the neighbouring node's state by a constant fraction;
- a squashing nonlinearity.

When a sample is accepted, the block computes the whole next state vector in one clock. Cell `i` takes its neighbour from the freshly computed value of cell `i-1`, so the chain of cells is evaluated combinationally in cell order. Cell 0 takes the previous value of cell `N-1` as its neighbour, which closes the loop. The result is identical to stepping a serial delay loop through all `N` nodes for that sample.

The constants are not loaded from anywhere. They are derived at elaboration from a seed parameter, so two instances with the same seed behave identically.

An optional register stage on the input is selected by `PIPE`. The output valid flag trails the input valid flag by the resulting latency. The block accepts one sample per cycle, back to back.

Top module: `rsv_lut_array`

## Requirements
- R1: While `rst_n` is low, every bit of `out_state` is zero and `out_valid` is low after the next rising clock edge.
- R2: Cell `i` computes `h = ((SEED + i*40503) * 2654435761) mod 2^32`. Its weight is `h[7:4]`, read as a signed 4-bit value. Its bias is `h[20:16]`, read as a signed 5-bit value.
- R3: For an accepted sample `u`, the new state of cell `i` is `sq(lk(nbr_i) + w_i*u + b_i)`. Here `nbr_0` is the old state of cell `N-1`, and for `i>0`, `nbr_i` is the new state of cell `i-1`.
- R4: The leak map is `lk(x) = floor(x*LEAK_NUM / 2^LEAK_SH)`, using floor division.
- R5: The squash map `sq(v)` leaves `|v| <= K` unchanged, where `K = 2^(DW-2)`. Otherwise the magnitude becomes `K + floor((|v|-K)/4)`. The magnitude is then limited to `2^(DW-1)-1`, and the sign of `v` is kept.
- R6: Samples presented on consecutive cycles are each applied in turn, with no gap required between them.
- R7: While no sample is being applied, `out_state` holds its value and `out_valid` stays low.
- R8: `out_valid` and the updated `out_state` appear exactly `1+PIPE` rising edges after the edge at which `in_valid` was sampled high.
- R9: Cell `i` occupies `out_state[i*DW +: DW]`.
- R10: The extreme input codes -8 and +7, applied repeatedly, follow R3 to R5 with no wraparound.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample present this cycle |
| in_sample | input | IW | Signed input sample |
| out_valid | output | 1 | State vector was updated by a sample |
| out_state | output | N*DW | Packed state vector, cell 0 in the low bits |

## Verification
A sample sampled at one rising edge changes `out_state` and raises `out_valid` `1+PIPE` edges later. With the bench's setting of `PIPE=1`, that is two edges. The bench keeps a history of its model's expected vectors that is `1+PIPE` entries deep. It compares the output against the oldest entry at each falling edge, before it drives the next sample. This way, idle cycles, back-to-back samples and held states are all checked in the exact cycle the result is due.

// File: rtl/rsv_lut_pkg.sv
package rsv_lut_pkg;

  // Per-cell constant hash derived from the seed.
  function automatic logic [31:0] cell_hash(input logic [31:0] seed, input int idx);
    logic [31:0] t;
    t = seed + 32'(idx) * 32'd40503;
    return t * 32'd2654435761;
  endfunction

  // Input-mask map: constant weight times sample plus constant bias.
  function automatic int mask_entry(input logic [31:0] seed, input int idx, input int u);
    logic [31:0] h;
    int w;
    int b;
    h = cell_hash(seed, idx);
    w = int'($signed(h[7:4]));
    b = int'($signed(h[20:16]));
    return w * u + b;
  endfunction

  // Leak map: constant fraction of the neighbour state, floor rounding.
  function automatic int leak_entry(input int x, input int num, input int sh);
    return (x * num) >>> sh;
  endfunction

  // Squash map: linear near zero, compressed beyond the knee, then limited.
  function automatic int squash_entry(input int v, input int knee, input int lim);
    int mag;
    mag = (v < 0) ? -v : v;
    if (mag > knee) mag = knee + ((mag - knee) >> 2);
    if (mag > lim) mag = lim;
    return (v < 0) ? -mag : mag;
  endfunction

endpackage

// File: rtl/rsv_in_stage.sv
module rsv_in_stage #(
  parameter int IW   = 4,
  parameter int PIPE = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [IW-1:0] in_sample,
  output logic          stg_valid,
  output logic [IW-1:0] stg_sample
);
  generate
    if (PIPE != 0) begin : g_reg
      logic          v_q;
      logic [IW-1:0] s_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q <= 1'b0;
          s_q <= '0;
        end else begin
          v_q <= in_valid;
          s_q <= in_sample;
        end
      end
      assign stg_valid  = v_q;
      assign stg_sample = s_q;
    end else begin : g_wire
      assign stg_valid  = in_valid;
      assign stg_sample = in_sample;
    end
  endgenerate
endmodule

// File: rtl/rsv_cell.sv
module rsv_cell
  import rsv_lut_pkg::*;
#(
  parameter int          DW       = 8,
  parameter int          IW       = 4,
  parameter int          CELL     = 0,
  parameter logic [31:0] SEED     = 32'h1234_5678,
  parameter int          LEAK_NUM = 6,
  parameter int          LEAK_SH  = 3
) (
  input  logic signed [IW-1:0] u,
  input  logic signed [DW-1:0] nbr,
  output logic signed [DW-1:0] nxt
);
  localparam int SW   = DW + 2;
  localparam int KNEE = 2 ** (DW - 2);
  localparam int LIM  = 2 ** (DW - 1) - 1;

  logic signed [SW-1:0] mask_v;
  logic signed [SW-1:0] leak_v;
  logic signed [SW-1:0] sum_v;

  // Three constant maps; CELL and SEED are fixed, so each reduces to a table.
  assign mask_v = SW'(mask_entry(SEED, CELL, int'(u)));
  assign leak_v = SW'(leak_entry(int'(nbr), LEAK_NUM, LEAK_SH));
  assign sum_v  = mask_v + leak_v;
  assign nxt    = DW'(squash_entry(int'(sum_v), KNEE, LIM));
endmodule

// File: rtl/rsv_lut_array.sv
module rsv_lut_array #(
  parameter int          N        = 16,
  parameter int          DW       = 8,
  parameter int          IW       = 4,
  parameter int          PIPE     = 0,
  parameter int          LEAK_NUM = 6,
  parameter int          LEAK_SH  = 3,
  parameter logic [31:0] SEED     = 32'h1234_5678
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [IW-1:0]   in_sample,
  output logic            out_valid,
  output logic [N*DW-1:0] out_state
);
  localparam int LAT = 1 + ((PIPE != 0) ? 1 : 0);

  logic          step;
  logic [IW-1:0] stg_sample;
  logic [DW-1:0] state_q [N];
  logic [DW-1:0] nbr     [N];
  logic [DW-1:0] nxt     [N];
  logic          ovalid_q;

  rsv_in_stage #(.IW(IW), .PIPE(PIPE)) u_in (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .stg_valid  (step),
    .stg_sample (stg_sample)
  );

  // The loop closure is wiring: cell 0 sees the old value of the last cell.
  assign nbr[0] = state_q[N-1];

  generate
    for (genvar i = 0; i < N; i++) begin : g_cell
      if (i > 0) begin : g_link
        assign nbr[i] = nxt[i-1];
      end
      rsv_cell #(
        .DW(DW), .IW(IW), .CELL(i), .SEED(SEED),
        .LEAK_NUM(LEAK_NUM), .LEAK_SH(LEAK_SH)
      ) u_cell (
        .u   (stg_sample),
        .nbr (nbr[i]),
        .nxt (nxt[i])
      );
      always_ff @(posedge clk) begin
        if (!rst_n)    state_q[i] <= '0;
        else if (step) state_q[i] <= nxt[i];
      end
      assign out_state[i*DW +: DW] = state_q[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) ovalid_q <= 1'b0;
    else        ovalid_q <= step;
  end
  assign out_valid = ovalid_q;
endmodule

// File: rtl/rsv_lut_array_chk.sv
module rsv_lut_array_chk #(
  parameter int N   = 16,
  parameter int DW  = 8,
  parameter int LAT = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            step,
  input logic            out_valid,
  input logic [N*DW-1:0] out_state
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (out_state == '0 && !out_valid));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(out_state));

  // R7
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> !out_valid);

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> out_valid);

  // R8
  valid_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, LAT));
endmodule

bind rsv_lut_array rsv_lut_array_chk #(.N(N), .DW(DW), .LAT(LAT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .step      (step),
  .out_valid (out_valid),
  .out_state (out_state)
);

// File: tb/rsv_lut_array_bench.sv
module rsv_lut_array_bench;
  localparam int          N        = 8;
  localparam int          DW       = 8;
  localparam int          IW       = 4;
  localparam int          PIPE     = 1;
  localparam int          LAT      = 1 + PIPE;
  localparam int          LEAK_NUM = 6;
  localparam int          LEAK_SH  = 3;
  localparam logic [31:0] SEED     = 32'hA5C3_0F17;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [IW-1:0]   in_sample = '0;
  logic            out_valid;
  logic [N*DW-1:0] out_state;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int              model [N];
  logic [N*DW-1:0] hist_s [4];
  bit              hist_v [4];

  always #5 clk = ~clk;

  rsv_lut_array #(
    .N(N), .DW(DW), .IW(IW), .PIPE(PIPE),
    .LEAK_NUM(LEAK_NUM), .LEAK_SH(LEAK_SH), .SEED(SEED)
  ) u_rsv_lut_array (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_state(out_state)
  );

  // R2: constants restated with 64-bit arithmetic and an explicit modulus.
  function automatic longint b_hash(input int i);
    longint t;
    t = (longint'(SEED) + longint'(i) * 40503) % 64'd4294967296;
    return (t * 64'd2654435761) % 64'd4294967296;
  endfunction

  function automatic int b_weight(input int i);
    int f;
    f = int'((b_hash(i) / 16) % 16);
    return (f >= 8) ? f - 16 : f;
  endfunction

  function automatic int b_bias(input int i);
    int f;
    f = int'((b_hash(i) / 65536) % 32);
    return (f >= 16) ? f - 32 : f;
  endfunction

  // R4: floor division written out by sign.
  function automatic int b_leak(input int x);
    int p;
    int d;
    p = x * LEAK_NUM;
    d = 1 << LEAK_SH;
    return (p >= 0) ? p / d : -((-p + d - 1) / d);
  endfunction

  // R5: squash restated by sign branch.
  function automatic int b_squash(input int v);
    int k;
    int lim;
    int r;
    k   = 2 ** (DW - 2);
    lim = 2 ** (DW - 1) - 1;
    if (v > k) begin
      r = k + (v - k) / 4;
      return (r > lim) ? lim : r;
    end else if (v < -k) begin
      r = k + (-v - k) / 4;
      return (r > lim) ? -lim : -r;
    end
    return v;
  endfunction

  // R3: serial recurrence over the nodes in loop order.
  task automatic model_step(input int u);
    int prev;
    prev = model[N-1];
    for (int i = 0; i < N; i++) begin
      model[i] = b_squash(b_leak(prev) + b_weight(i) * u + b_bias(i));
      prev = model[i];
    end
  endtask

  // R9: cell i packed at [i*DW +: DW].
  function automatic logic [N*DW-1:0] model_word();
    logic [N*DW-1:0] w;
    for (int i = 0; i < N; i++) w[i*DW +: DW] = DW'(model[i]);
    return w;
  endfunction

  task automatic tick(input bit v, input int u, input string tag);
    checks++;
    if (out_state !== hist_s[LAT-1]) begin
      errors++;
      $display("FAIL %s state actual %h expected %h", tag, out_state, hist_s[LAT-1]);
    end
    checks++;
    if (out_valid !== hist_v[LAT-1]) begin
      errors++;
      $display("FAIL R8 valid actual %0b expected %0b", out_valid, hist_v[LAT-1]);
    end
    for (int k = 3; k > 0; k--) begin
      hist_s[k] = hist_s[k-1];
      hist_v[k] = hist_v[k-1];
    end
    in_valid  = v;
    in_sample = IW'(u);
    if (v) model_step(u);
    hist_s[0] = model_word();
    hist_v[0] = v;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < N; i++) model[i] = 0;
    for (int k = 0; k < 4; k++) begin
      hist_s[k] = '0;
      hist_v[k] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    checks++;
    if (out_state !== '0 || out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset actual %h/%0b expected 0/0", out_state, out_valid);
    end
    rst_n = 1'b1;
    // R10: extremes repeated, deep into the squash region.
    for (int j = 0; j < 6; j++) tick(1'b1, -8, "R10");
    for (int j = 0; j < 6; j++) tick(1'b1, 7, "R10");
    // R7: idle cycles hold the vector.
    for (int j = 0; j < 5; j++) tick(1'b0, 3, "R7");
    // R6: back-to-back alternating samples.
    for (int j = 0; j < 8; j++) tick(1'b1, (j % 2) ? 5 : -3, "R6");
    tick(1'b1, 0, "R3");
    tick(1'b0, -8, "R7");
    tick(1'b1, 1, "R3");
    // R3 R4 R5: random stream with gaps.
    void'($urandom(32'd2024));
    for (int j = 0; j < 400; j++) begin
      tick(($urandom % 10) < 7, int'($urandom % 16) - 8, "R3");
    end
    for (int j = 0; j < 4; j++) tick(1'b0, 0, "R7");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule